// File: doc/BRIEF.md
# Two-Wire Bus Acquisition and Recovery Controller

This controller decides when a device on a shared open-drain two-wire bus (one clock line, one data line) may safely become bus master. When the local logic raises a request, the controller watches the clock and data lines through synchronizers and runs an idle-qualification timer. It restarts the timer on any bus activity. It grants mastership only after a full quiet period in which both lines are high.

When the data line is low at the end of a quiet period, the bus is stuck. The controller then pulses the clock line a bounded number of times until the data line is released. It then issues a START followed by a STOP to reset the other devices, and grants the bus. When the clock line is low for a whole period, the controller backs off for one more period before it tries again. A recovery that runs out of pulses raises a failure flag for one period, after which qualification starts again. The controller only ever pulls a line low, through an output enable. Byte transfers and addressing belong to the master logic that receives the grant.

States: IDLE (no request), QUAL (qualification timer running), HOLD (back-off after the clock line was low for a whole period), RCV_LO and RCV_HI (recovery pulse, clock pulled low and then released), GEN_START and GEN_STOP (reset sequence), GRANT (mastership held), FAIL (recovery exhausted). The transitions are:
- IDLE→QUAL on request.
- In QUAL, bus activity reloads the timer. On expiry, QUAL goes to HOLD if the clock line is low, to RCV_LO if the data line is low, and to GRANT otherwise.
- HOLD→QUAL and FAIL→QUAL on expiry.
- RCV_LO→RCV_HI after the low time.
- At the end of the high time, RCV_HI goes to GEN_START if the data line is high, to FAIL after the last allowed pulse, and to RCV_LO otherwise.
- GEN_START→GEN_STOP→GRANT, each after its own timed phase.
- Any state goes to IDLE when the request drops.

Top module: `twb_acquire`

## Requirements
- R1: After reset, and while no request is present, scl_oe_o, sda_oe_o, grant_o and recov_fail_o are all 0.
- R2: A rising request starts a qualification period of QUAL_CYC cycles. If the period runs out with both synchronized lines high, grant_o rises one cycle later, which is QUAL_CYC+1 cycles after the request is first sampled. It never rises earlier.
- R3: Every change of the synchronized clock line during qualification restarts the full QUAL_CYC period.
- R4: A START (data falls while clock is high) or a STOP (data rises while clock is high) during qualification restarts the full QUAL_CYC period.
- R5: If the clock line stays low for a whole qualification period, the controller waits one more QUAL_CYC period without watching the bus, then qualifies again.
- R6: If the data line is low when qualification expires, the controller produces recovery pulses. For each pulse, scl_oe_o is 1 for PULSE_LO_CYC cycles and then 0 for PULSE_HI_CYC cycles. The data line is sampled at the end of each released phase, and there are never more than MAX_PULSES pulses.
- R7: Once the data line reads high after a pulse, sda_oe_o is 1 for PULSE_LO_CYC cycles with the clock released (a START), then 0 for PULSE_HI_CYC cycles (a STOP). grant_o rises after that.
- R8: If the data line is still low after MAX_PULSES pulses, recov_fail_o is 1 for QUAL_CYC cycles with no grant, and qualification then restarts.
- R9: When the request drops in any state, the controller returns to idle within one cycle: grant_o falls and both enables are released.
- R10: An enable value of 1 pulls its line low and 0 releases it. scl_oe_o and sda_oe_o are never 1 in the same cycle, and neither is 1 during qualification or while granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Mastership request, held high while the bus is wanted |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| grant_o | output | 1 | Mastership granted, bus idle |
| recov_fail_o | output | 1 | Stuck-bus recovery exhausted its pulses |

## Verification
The assertions assume that req_i is synchronous to clk. They also assume that the line inputs are the wired-AND of every driver on the bus, so a released enable shows up as a high level unless another device pulls the line low. The bench builds the lines as exactly that wired-AND of its own drivers, the controller's enables and a model of a stuck device. That device holds the data line low and lets go only on a falling clock line. The bench changes its inputs just after a rising edge and keeps PULSE_HI_CYC longer than the synchronizer delay, so every data sample that the recovery takes sees a settled line.

// File: rtl/twb_acq_pkg.sv
package twb_acq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_QUAL,
        S_HOLD,
        S_RCV_LO,
        S_RCV_HI,
        S_GEN_START,
        S_GEN_STOP,
        S_GRANT,
        S_FAIL
    } acq_state_e;

endpackage

// File: rtl/twb_line_sync.sv
// Multi-stage synchronizer for the bus lines; resets to the idle (high) level.
module twb_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] pipe;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe <= '1;
                end else begin
                    pipe <= {pipe[STAGES-2:0], d_i[g]};
                end
            end

            assign q_o[g] = pipe[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/twb_bus_watch.sv
// Activity detector: clock-line edges and START / STOP conditions.
module twb_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_edge_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_edge_o = scl_s ^ scl_q;
    assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twb_dtimer.sv
// Reloadable down-counter: a load of N makes done_o rise N cycles later.
module twb_dtimer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= load_val_i - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign done_o = (cnt == '0);

endmodule

// File: rtl/twb_acquire.sv
module twb_acquire
    import twb_acq_pkg::*;
#(
    parameter int QUAL_CYC     = 3_300_000,
    parameter int PULSE_LO_CYC = 500,
    parameter int PULSE_HI_CYC = 500,
    parameter int MAX_PULSES   = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic grant_o,
    output logic recov_fail_o
);

    localparam int PULSE_MAX = (PULSE_LO_CYC > PULSE_HI_CYC) ? PULSE_LO_CYC : PULSE_HI_CYC;
    localparam int LONGEST   = (QUAL_CYC > PULSE_MAX) ? QUAL_CYC : PULSE_MAX;
    localparam int TW        = $clog2(LONGEST + 1);
    localparam int PW        = $clog2(MAX_PULSES + 1);

    localparam logic [TW-1:0] QUAL_LV = TW'(QUAL_CYC);
    localparam logic [TW-1:0] PLO_LV  = TW'(PULSE_LO_CYC);
    localparam logic [TW-1:0] PHI_LV  = TW'(PULSE_HI_CYC);
    localparam logic [PW-1:0] LAST_PC = PW'(MAX_PULSES - 1);
    localparam logic [PW-1:0] MAX_PC  = PW'(MAX_PULSES);

    // ---------------------------------------------------------------
    // Line synchronization and activity detection
    // ---------------------------------------------------------------
    logic [1:0] line_raw;
    logic [1:0] line_s;
    logic       scl_s;
    logic       sda_s;

    assign line_raw = {sda_i, scl_i};

    twb_line_sync #(
        .LINES  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_raw),
        .q_o   (line_s)
    );

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    logic scl_edge;
    logic start_det;
    logic stop_det;
    logic bus_evt;

    twb_bus_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_edge_o (scl_edge),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign bus_evt = scl_edge | start_det | stop_det;

    // ---------------------------------------------------------------
    // Shared interval timer
    // ---------------------------------------------------------------
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;

    twb_dtimer #(
        .W (TW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    // ---------------------------------------------------------------
    // State machine
    // ---------------------------------------------------------------
    acq_state_e    st;
    acq_state_e    nxt;
    logic [PW-1:0] pcnt;
    logic          pc_clr;
    logic          pc_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            pcnt <= '0;
        end else begin
            st <= nxt;
            if (pc_clr) begin
                pcnt <= '0;
            end else if (pc_inc) begin
                pcnt <= pcnt + PW'(1);
            end
        end
    end

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = QUAL_LV;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        if (!req_i && (st != S_IDLE)) begin
            nxt = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (req_i) begin
                        nxt      = S_QUAL;
                        tmr_load = 1'b1;
                    end
                end
                S_QUAL: begin
                    if (bus_evt) begin
                        tmr_load = 1'b1;
                    end else if (tmr_done) begin
                        if (!scl_s) begin
                            nxt      = S_HOLD;
                            tmr_load = 1'b1;
                        end else if (!sda_s) begin
                            nxt      = S_RCV_LO;
                            tmr_load = 1'b1;
                            tmr_val  = PLO_LV;
                            pc_clr   = 1'b1;
                        end else begin
                            nxt = S_GRANT;
                        end
                    end
                end
                S_HOLD, S_FAIL: begin
                    if (tmr_done) begin
                        nxt      = S_QUAL;
                        tmr_load = 1'b1;
                    end
                end
                S_RCV_LO: begin
                    if (tmr_done) begin
                        nxt      = S_RCV_HI;
                        tmr_load = 1'b1;
                        tmr_val  = PHI_LV;
                    end
                end
                S_RCV_HI: begin
                    if (tmr_done) begin
                        tmr_load = 1'b1;
                        if (sda_s) begin
                            nxt     = S_GEN_START;
                            tmr_val = PLO_LV;
                        end else begin
                            pc_inc = 1'b1;
                            if (pcnt == LAST_PC) begin
                                nxt = S_FAIL;
                            end else begin
                                nxt     = S_RCV_LO;
                                tmr_val = PLO_LV;
                            end
                        end
                    end
                end
                S_GEN_START: begin
                    if (tmr_done) begin
                        nxt      = S_GEN_STOP;
                        tmr_load = 1'b1;
                        tmr_val  = PHI_LV;
                    end
                end
                S_GEN_STOP: begin
                    if (tmr_done) begin
                        nxt = S_GRANT;
                    end
                end
                S_GRANT: begin
                    nxt = S_GRANT;
                end
                default: begin
                    nxt = S_IDLE;
                end
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        scl_oe_o     = 1'b0;
        sda_oe_o     = 1'b0;
        grant_o      = 1'b0;
        recov_fail_o = 1'b0;
        unique case (st)
            S_RCV_LO:    scl_oe_o     = 1'b1;
            S_GEN_START: sda_oe_o     = 1'b1;
            S_GRANT:     grant_o      = 1'b1;
            S_FAIL:      recov_fail_o = 1'b1;
            default:     ;
        endcase
    end

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    AST_GRANT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> ($past(st) == S_QUAL || $past(st) == S_GEN_STOP)); // R7

    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= MAX_PC); // R6

    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recov_fail_o) |-> (pcnt == MAX_PC)); // R8

    AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !req_i) |=> !grant_o); // R9

    AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_oe_o && sda_oe_o)); // R10

    AST_QUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_QUAL && $past(st) == S_QUAL) |-> (!scl_oe_o && !sda_oe_o)); // R10

endmodule

// File: tb/twb_acquire_tb_top.sv
module twb_acquire_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P    = 40;
    localparam int PLO  = 3;
    localparam int PHI  = 3;
    localparam int NPUL = 10;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic req   = 1'b0;
    logic ext_scl = 1'b1;
    logic ext_sda = 1'b1;
    logic slave_hold = 1'b0;
    int   slave_left = 0;

    logic scl_oe, sda_oe, grant, fail;
    logic scl_line, sda_line;

    assign scl_line = ext_scl & ~scl_oe;
    assign sda_line = ext_sda & ~sda_oe & ~slave_hold;

    twb_acquire #(
        .QUAL_CYC     (P),
        .PULSE_LO_CYC (PLO),
        .PULSE_HI_CYC (PHI),
        .MAX_PULSES   (NPUL),
        .SYNC_STAGES  (2)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .grant_o      (grant),
        .recov_fail_o (fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    // Stuck device: holds data low, lets go after a number of clock falls
    always @(negedge scl_line) begin
        if (slave_hold) begin
            if (slave_left <= 1) slave_hold = 1'b0;
            else slave_left--;
        end
    end

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    kind;   // 0 = grant rise, 1 = failure flag rise
        int    lo;
        int    hi;
        string tag;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_evt(input int kind, input int lo, input int hi, input string tag);
        exp_t e;
        e.kind = kind; e.lo = lo; e.hi = hi; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) step(1);
    endtask

    // Monitor
    int   pulses = 0, oe_cyc = 0, starts = 0, stops = 0, overlap = 0;
    logic prev_g = 1'b0, prev_f = 1'b0, prev_oe = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    task automatic take_evt(input int kind);
        exp_t e;
        checks++;
        if (sbq.size() == 0) begin
            errors++;
            $display("FAIL R2/R8: unexpected event kind=%0d at cycle %0d, expected none", kind, cyc);
        end else begin
            e = sbq.pop_front();
            if (e.kind != kind || cyc < e.lo || cyc > e.hi) begin
                errors++;
                $display("FAIL %s: actual kind=%0d cycle=%0d expected kind=%0d cycle in [%0d,%0d]",
                         e.tag, kind, cyc, e.kind, e.lo, e.hi);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (grant && !prev_g) take_evt(0);
            if (fail && !prev_f) take_evt(1);
            if (scl_oe && !prev_oe) pulses++;
            if (scl_oe) oe_cyc++;
            if (scl_oe && sda_oe) overlap++;
            if (prev_scl && scl_line && prev_sda && !sda_line) starts++;
            if (prev_scl && scl_line && !prev_sda && sda_line) stops++;
        end
        prev_g   = grant;
        prev_f   = fail;
        prev_oe  = scl_oe;
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=completion");
        summary();
        $finish;
    end

    initial begin
        int c;
        int e;

        // R1: reset state
        step(4);
        @(negedge clk);
        check(scl_oe == 1'b0, "R1 scl_oe in reset", scl_oe, 0);
        check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        check(grant == 1'b0, "R1 grant in reset", grant, 0);
        check(fail == 1'b0, "R1 fail in reset", fail, 0);
        step(1);
        rst_n = 1'b1;
        step(6);
        @(negedge clk);
        check(!scl_oe && !sda_oe && !grant, "R1 idle without request", {scl_oe, sda_oe, grant}, 0);

        // R2: idle bus, plain qualification
        step(1);
        c = cyc;
        req = 1'b1;
        expect_evt(0, c + P, c + P + 3, "R2");
        step(P / 2);
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R10 no drive while qualifying", {scl_oe, sda_oe}, 0);
        check(grant == 1'b0, "R2 no early grant", grant, 0);
        wait_until(c + P + 6);
        req = 1'b0;
        step(2);
        @(negedge clk);
        check(grant == 1'b0, "R9 grant drops with request", grant, 0);
        step(4);

        // R3: clock-line activity restarts the timer
        c = cyc;
        req = 1'b1;
        for (int i = 0; i < 8; i++) begin
            step(10);
            ext_scl = ~ext_scl;
        end
        e = cyc;
        expect_evt(0, e + P + 1, e + P + 5, "R3");
        wait_until(e + P + 8);
        req = 1'b0;
        step(4);

        // R4: START then STOP restart the timer
        req = 1'b1;
        step(15);
        ext_sda = 1'b0;
        step(15);
        ext_sda = 1'b1;
        e = cyc;
        expect_evt(0, e + P + 1, e + P + 5, "R4");
        wait_until(e + P + 8);
        req = 1'b0;
        step(4);

        // R5: clock held low a whole period -> back-off
        ext_scl = 1'b0;
        step(5);
        c = cyc;
        req = 1'b1;
        expect_evt(0, c + 3 * P, c + 3 * P + 3, "R5");
        step(P + 10);
        ext_scl = 1'b1;
        wait_until(c + 3 * P + 6);
        req = 1'b0;
        step(4);

        // R6/R7: stuck data released after four pulses
        slave_left = 4;
        slave_hold = 1'b1;
        step(5);
        pulses = 0; oe_cyc = 0; starts = 0; stops = 0;
        c = cyc;
        req = 1'b1;
        expect_evt(0, c + P + 29, c + P + 34, "R7");
        wait_until(c + P + 40);
        check(pulses == 4, "R6 recovery pulse count", pulses, 4);
        check(oe_cyc == 4 * PLO, "R6 clock low time", oe_cyc, 4 * PLO);
        check(starts == 1, "R7 START issued", starts, 1);
        check(stops == 1, "R7 STOP issued", stops, 1);
        req = 1'b0;
        step(4);

        // R8: data never released -> failure flag, then requalify
        slave_left = 1000;
        slave_hold = 1'b1;
        step(5);
        pulses = 0;
        c = cyc;
        req = 1'b1;
        expect_evt(1, c + P + 59, c + P + 63, "R8");
        wait_until(c + P + 66);
        @(negedge clk);
        check(pulses == NPUL, "R8 pulses before failure", pulses, NPUL);
        check(grant == 1'b0, "R8 no grant on failure", grant, 0);
        step(1);
        slave_hold = 1'b0;
        expect_evt(0, c + 3 * P + 59, c + 3 * P + 64, "R8");
        wait_until(c + 3 * P + 68);
        req = 1'b0;
        step(4);

        // R9: request dropped in the middle of recovery
        slave_left = 1000;
        slave_hold = 1'b1;
        step(5);
        c = cyc;
        req = 1'b1;
        wait_until(c + P + 8);
        req = 1'b0;
        step(3);
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R9 lines released on drop", {scl_oe, sda_oe}, 0);
        step(1);
        slave_hold = 1'b0;
        step(P);
        @(negedge clk);
        check(grant == 1'b0, "R9 no grant after drop", grant, 0);

        // R9: request dropped during qualification
        step(1);
        req = 1'b1;
        step(10);
        req = 1'b0;
        step(2 * P);
        @(negedge clk);
        check(grant == 1'b0, "R9 no grant after early drop", grant, 0);

        check(sbq.size() == 0, "R2 all expected grants seen", sbq.size(), 0);
        check(overlap == 0, "R10 enables never together", overlap, 0);

        summary();
        $finish;
    end

endmodule